// File: doc/BRIEF.md
# Instrument Status Register Hierarchy

This block gathers the fault and status reporting of a multi-channel instrument into one status byte. Nine live fault conditions are sampled every clock. Edge filters decide which changes of each condition are worth recording, and the chosen changes are latched into a sticky questionable event register. A second group latches one sticky bit per channel each time that channel's already-masked status flag goes high. Each event group is masked by an enable register and ORed into its own fixed bit of the status byte. A message-available flag from an external output queue is copied into a third bit.

Software reaches the block through a small synchronous register port. Writes program the two edge filters and the two enable masks. A one-cycle read strobe returns any register one clock later. Reading either event register hands back its contents and clears it in the same step. If a new qualifying edge arrives in that same cycle, it is kept and does not vanish with the clear.

Top module: `status_hier`

## Requirements
- R1: The condition register (address 0) returns the nine fault inputs as sampled at the previous clock edge. Bit order: 0 over-temperature, 1 over-voltage, 2 over-current, 3 over-power, 4 reverse input voltage, 5 sync timeout, 6 sine current limit, 7 fan failure, 8 remote inhibit.
- R2: When a condition bit goes from 0 to 1 between two samples and its bit in the rising-edge filter (address 1) is set, the matching questionable event bit is set.
- R3: When a condition bit goes from 1 to 0 and its bit in the falling-edge filter (address 2) is set, the matching event bit is set. With both filters set, both edges latch. With neither set, no edge latches.
- R4: Event bits are sticky. Once set, they stay set through any later input activity until a clearing read.
- R5: A read of the questionable event register (address 3) returns its value and clears it. An edge that qualifies in the same cycle leaves its bit set after the read.
- R6: Status byte bit 3 is the OR of the questionable event bits ANDed with the questionable enable mask (address 4).
- R7: Channel summary event bit i (address 5, bits 0..9) is set when channel flag i rises. It is sticky, and a read returns the bits and clears them, with the same rule for an edge in the read cycle.
- R8: Status byte bit 2 is the OR of the channel summary event bits ANDed with the channel enable mask (address 6).
- R9: Status byte bit 4 follows the message-available input, one clock later.
- R10: After reset, the rising-edge filter is all ones. The falling-edge filter, both enables, both event registers, the read data and the status byte are all zero. Status byte bits 0, 1, 5, 6 and 7 are always zero.
- R11: `rdata` loads the addressed register on the clock edge that samples `rd_en` and holds it until the next read. Address 7 returns the status byte, zero-extended. Unused upper data bits read as zero. Writes to addresses 1, 2, 4 and 6 take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | 9 | Live fault condition bits |
| chan_flag | input | 10 | Per-channel masked status flag |
| mav_in | input | 1 | Output queue holds data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| status_byte | output | 8 | Summary status byte |

## Verification
The edge filters are exercised with single pulses, steady levels, and noise-like patterns on all nine conditions. These are run under rising-only, falling-only, both-edge and no-edge settings, which separates edge detection from level detection and each filter from the other. Reads are issued in cycles that carry fresh edges, which separates a clear that loses events from one that keeps them. The enable masks are swept while events are pending, to show that each summary bit tracks only its own group and its own mask. The message-available flag is toggled on its own, so its copy can be told apart from the event summaries.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [2:0] {
    RA_QCOND = 3'd0,
    RA_QRISE = 3'd1,
    RA_QFALL = 3'd2,
    RA_QEVT  = 3'd3,
    RA_QMASK = 3'd4,
    RA_CEVT  = 3'd5,
    RA_CMASK = 3'd6,
    RA_STB   = 3'd7
  } reg_addr_e;

  localparam int STB_W    = 8;
  localparam int STB_CSUM = 2;
  localparam int STB_QSUM = 3;
  localparam int STB_MAV  = 4;
endpackage

// File: rtl/edge_latch.sv
module edge_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] fall_sel,
  input  logic         clr,
  output logic [W-1:0] level_q,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] hit;

  always_comb begin
    hit = (sig & ~level_q & rise_sel) | (~sig & level_q & fall_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      evt_q   <= '0;
    end else begin
      level_q <= sig;
      evt_q   <= (clr ? '0 : evt_q) | hit;
    end
  end

  // R4: without a clear, no set bit drops
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R5 / R7: after a clear only bits hit in that cycle remain
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((evt_q & ~$past(hit)) == '0));

  // R2 / R3: a new bit appears only from a qualifying edge
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import status_pkg::*;
#(
  parameter int QW = 9,
  parameter int CW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [QW-1:0] q_rise,
  output logic [QW-1:0] q_fall,
  output logic [QW-1:0] q_mask,
  output logic [CW-1:0] c_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_rise <= '1;
      q_fall <= '0;
      q_mask <= '0;
      c_mask <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_QRISE: q_rise <= wdata[QW-1:0];
        RA_QFALL: q_fall <= wdata[QW-1:0];
        RA_QMASK: q_mask <= wdata[QW-1:0];
        RA_CMASK: c_mask <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // R10: reset leaves rising-only filtering and closed masks
  assert_reset_vals_R10: assert property (@(posedge clk)
    rst |=> (q_rise == '1 && q_fall == '0 && q_mask == '0 && c_mask == '0));
endmodule

// File: rtl/status_readback.sv
module status_readback
  import status_pkg::*;
#(
  parameter int QW = 9,
  parameter int CW = 10,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [QW-1:0]    q_level,
  input  logic [QW-1:0]    q_rise,
  input  logic [QW-1:0]    q_fall,
  input  logic [QW-1:0]    q_evt,
  input  logic [QW-1:0]    q_mask,
  input  logic [CW-1:0]    c_evt,
  input  logic [CW-1:0]    c_mask,
  input  logic             mav_in,
  output logic [DW-1:0]    rdata,
  output logic [STB_W-1:0] stb
);
  logic [DW-1:0]    rd_d;
  logic [STB_W-1:0] stb_d;

  always_comb begin
    stb_d           = '0;
    stb_d[STB_CSUM] = |(c_evt & c_mask);
    stb_d[STB_QSUM] = |(q_evt & q_mask);
    stb_d[STB_MAV]  = mav_in;
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr_e'(addr))
      RA_QCOND: rd_d[QW-1:0]    = q_level;
      RA_QRISE: rd_d[QW-1:0]    = q_rise;
      RA_QFALL: rd_d[QW-1:0]    = q_fall;
      RA_QEVT:  rd_d[QW-1:0]    = q_evt;
      RA_QMASK: rd_d[QW-1:0]    = q_mask;
      RA_CEVT:  rd_d[CW-1:0]    = c_evt;
      RA_CMASK: rd_d[CW-1:0]    = c_mask;
      RA_STB:   rd_d[STB_W-1:0] = stb;
      default:  rd_d            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      stb   <= '0;
    end else begin
      stb <= stb_d;
      if (rd_en) rdata <= rd_d;
    end
  end

  // R9: message-available copied one clock later
  assert_mav_set_R9: assert property (@(posedge clk) disable iff (rst)
    mav_in |=> stb[STB_MAV]);
  assert_mav_clr_R9: assert property (@(posedge clk) disable iff (rst)
    !mav_in |=> !stb[STB_MAV]);
  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/status_hier.sv
module status_hier
  import status_pkg::*;
#(
  parameter int QW = 9,
  parameter int NCH = 10,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [QW-1:0]    cond_in,
  input  logic [NCH-1:0]   chan_flag,
  input  logic             mav_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [STB_W-1:0] status_byte
);
  localparam logic [NCH-1:0] CH_RISE_ONLY = '1;
  localparam logic [NCH-1:0] CH_NO_FALL   = '0;

  logic [QW-1:0]  q_rise, q_fall, q_mask, q_level, q_evt;
  logic [NCH-1:0] c_mask, c_level, c_evt;
  logic           q_clr, c_clr;

  assign q_clr = rd_en && (reg_addr_e'(addr) == RA_QEVT);
  assign c_clr = rd_en && (reg_addr_e'(addr) == RA_CEVT);

  cfg_regs #(.QW(QW), .CW(NCH), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .q_rise(q_rise), .q_fall(q_fall), .q_mask(q_mask), .c_mask(c_mask)
  );

  edge_latch #(.W(QW)) u_ques (
    .clk(clk), .rst(rst), .sig(cond_in), .rise_sel(q_rise),
    .fall_sel(q_fall), .clr(q_clr), .level_q(q_level), .evt_q(q_evt)
  );

  edge_latch #(.W(NCH)) u_chan (
    .clk(clk), .rst(rst), .sig(chan_flag), .rise_sel(CH_RISE_ONLY),
    .fall_sel(CH_NO_FALL), .clr(c_clr), .level_q(c_level), .evt_q(c_evt)
  );

  status_readback #(.QW(QW), .CW(NCH), .DW(DW)) u_rb (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .q_level(q_level), .q_rise(q_rise), .q_fall(q_fall), .q_evt(q_evt),
    .q_mask(q_mask), .c_evt(c_evt), .c_mask(c_mask), .mav_in(mav_in),
    .rdata(rdata), .stb(status_byte)
  );

  // R10: unused status byte positions stay zero
  assert_stb_unused_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_byte[1:0] == 2'b00 && status_byte[7:5] == 3'b000));
  // R1: the condition register tracks the inputs one clock late
  assert_cond_sample_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_level == $past(cond_in)));
endmodule

// File: tb/sim_status_hier.sv
module sim_status_hier;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  cond_in = '0;
  logic [9:0]  chan_flag = '0;
  logic        mav_in = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  status_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [8:0]  m_cond, m_ptr, m_ntr, m_qev, m_qen;
  logic [9:0]  m_cprev, m_cev, m_cen;
  logic [7:0]  m_stb;
  logic [15:0] m_rd;

  status_hier u0 (
    .clk(clk), .rst(rst), .cond_in(cond_in), .chan_flag(chan_flag),
    .mav_in(mav_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .status_byte(status_byte)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic model_step();
    logic [8:0]  rise, fall, nq;
    logic [9:0]  nc;
    logic [15:0] nrd;
    logic [7:0]  ns;
    if (rst) begin
      m_cond = '0; m_ptr = '1; m_ntr = '0; m_qev = '0; m_qen = '0;
      m_cprev = '0; m_cev = '0; m_cen = '0; m_stb = '0; m_rd = '0;
      return;
    end
    rise = cond_in & ~m_cond;
    fall = ~cond_in & m_cond;
    nq = ((rd_en && addr == 3'd3) ? 9'd0 : m_qev) | (rise & m_ptr) | (fall & m_ntr);
    nc = ((rd_en && addr == 3'd5) ? 10'd0 : m_cev) | (chan_flag & ~m_cprev);
    nrd = m_rd;
    if (rd_en) begin
      case (addr)
        3'd0: nrd = {7'd0, m_cond};
        3'd1: nrd = {7'd0, m_ptr};
        3'd2: nrd = {7'd0, m_ntr};
        3'd3: nrd = {7'd0, m_qev};
        3'd4: nrd = {7'd0, m_qen};
        3'd5: nrd = {6'd0, m_cev};
        3'd6: nrd = {6'd0, m_cen};
        default: nrd = {8'd0, m_stb};
      endcase
    end
    ns = {3'b000, mav_in, |(m_qev & m_qen), |(m_cev & m_cen), 2'b00};
    if (wr_en) begin
      case (addr)
        3'd1: m_ptr = wdata[8:0];
        3'd2: m_ntr = wdata[8:0];
        3'd4: m_qen = wdata[8:0];
        3'd6: m_cen = wdata[9:0];
        default: ;
      endcase
    end
    m_qev = nq; m_cev = nc; m_rd = nrd; m_stb = ns;
    m_cond = cond_in; m_cprev = chan_flag;
  endtask

  task automatic tick(input string tag, input logic we, input logic re,
                      input logic [2:0] a, input logic [15:0] d);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (rdata !== m_rd) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, m_rd);
    end
    checks++;
    if (status_byte !== m_stb) begin
      errors++;
      $display("FAIL %s status_byte actual=%h expected=%h", tag, status_byte, m_stb);
    end
    wr_en = 0; rd_en = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag, 0, 0, 3'd0, 16'd0);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    tick(tag, 0, 1, a, 16'd0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [15:0] d);
    tick(tag, 1, 0, a, d);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    rst = 1;
    idle("R10 reset", 3);
    rst = 0;
    // R10 / R11: reset values through the read port
    for (int a = 0; a < 8; a++) rd("R10 reset readback", a[2:0]);
    // R1: condition sampling
    cond_in = 9'h155; idle("R1 cond", 1); rd("R1 cond read", 3'd0);
    // R2: rising edges latch under default filter, R5 read clears
    rd("R2 rise event", 3'd3); rd("R5 cleared", 3'd3);
    // R3: falling-only filter
    wr("R3 rise filter off", 3'd1, 16'h0000);
    wr("R3 fall filter on", 3'd2, 16'h01FF);
    cond_in = 9'h0AA; idle("R3 fall", 2); rd("R3 fall event", 3'd3);
    // R3: both filters, then neither
    wr("R3 both", 3'd1, 16'h00F0);
    cond_in = 9'h0F5; idle("R3 both edges", 1);
    cond_in = 9'h005; idle("R3 both edges", 1); rd("R3 both read", 3'd3);
    wr("R3 none rise", 3'd1, 16'h0000); wr("R3 none fall", 3'd2, 16'h0000);
    cond_in = 9'h1FA; idle("R3 no edges", 2); rd("R3 none read", 3'd3);
    // R4: short pulse stays latched
    wr("R4 rise all", 3'd1, 16'h01FF);
    cond_in = 9'h000; idle("R4", 1);
    cond_in = 9'h101; idle("R4 pulse", 1);
    cond_in = 9'h000; idle("R4 hold", 5); rd("R4 sticky read", 3'd3);
    // R5: edge in the clearing cycle survives
    cond_in = 9'h010; idle("R5", 1);
    cond_in = 9'h030; rd("R5 read with edge", 3'd3); rd("R5 kept", 3'd3);
    // R6: mask sweep
    cond_in = 9'h000; idle("R6", 1);
    cond_in = 9'h004; idle("R6 evt", 2);
    wr("R6 mask miss", 3'd4, 16'h0001); idle("R6 masked off", 2);
    wr("R6 mask hit", 3'd4, 16'h0004); idle("R6 summary on", 2);
    rd("R6 clear", 3'd3); idle("R6 summary off", 2);
    // R7 / R8: channel summary
    chan_flag = 10'h201; idle("R7 rise", 2);
    chan_flag = 10'h000; idle("R7 fall ignored", 2); rd("R7 read", 3'd5);
    chan_flag = 10'h040; idle("R8", 1);
    wr("R8 mask", 3'd6, 16'h0040); idle("R8 summary", 2);
    chan_flag = 10'h0C0; rd("R7 read with edge", 3'd5); rd("R7 kept", 3'd5);
    idle("R8 after", 2); rd("R11 cmask", 3'd6);
    // R9: message available
    mav_in = 1; idle("R9 on", 2); rd("R11 stb read", 3'd7);
    mav_in = 0; idle("R9 off", 2);
    // mixed noise on all inputs
    wr("R3 fall mix", 3'd2, 16'h0155);
    wr("R6 mask all", 3'd4, 16'h01FF);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cond_in = lfsr[8:0];
      chan_flag = lfsr[18:9];
      mav_in = lfsr[19];
      if (lfsr[23:22] == 2'b00) rd("R11 mixed read", lfsr[26:24]);
      else if (lfsr[23:22] == 2'b01 && lfsr[26:24] inside {3'd1, 3'd2, 3'd4, 3'd6})
        wr("R11 mixed write", lfsr[26:24], lfsr[15:0]);
      else idle("R4 mixed", 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule